// File: doc/BRIEF.md
# Transaction Event Counter Bank

This block keeps five counters of activity for one cache cluster. Counter 0 counts clock cycles. Counters 1 to 4 count pulses on four event inputs: memory write, memory read, snoop read and coherent-port write. All five counters share one configuration word. That word holds an enable bit, a counter-reset bit and an overflow-clear bit for each counter, at fixed offsets from the counter index.

A counter that wraps past its maximum value sets a sticky flag in a read-only status word. The interrupt line stays high for as long as any flag is set. Software reads counters and status through a simple 32-bit register port, with a single-cycle write strobe and a combinational read. To clear a counter, software writes its reset bit to 1 and then back to 0. An overflow flag is cleared the same way, through its overflow-clear bit.

Top module: `txn_event_bank`

## Requirements
- R1: After reset, all counters, all overflow flags and the configuration word are zero, and `irq` is low.
- R2: The configuration word sits at offset 0x54c and has three fields:
  - bit i enables counter i;
  - bit 5+i resets counter i;
  - bit 18+i clears the overflow flag of counter i.

  Only bits 0–9 and 18–22 are stored. All other bits read back as 0.
- R3: While the reset bit of counter i is 1, the counter is held at zero. This takes priority over counting.
- R4: Counter 0 increments on every clock while it is enabled. Counter i (i = 1..4) increments on each clock in which `evt_pulse[i-1]` is high while the counter is enabled. A disabled counter holds its value.
- R5: When a counter steps from all ones to zero, its overflow flag sets. The flag is bit i of the status word at offset 0x560.
- R6: An overflow flag stays set until its overflow-clear bit is written to 1. While that bit is 1, the flag is held clear, even if the counter wraps again.
- R7: `irq` is high exactly when at least one overflow flag is set.
- R8: Counter i is read at offset 0x634 + 4·i. The value is zero-extended to 32 bits.
- R9: Reads of any other offset return zero. Writes are ignored at unmapped offsets, at the status offset and at the counter offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 4 | Event inputs for counters 1..4 |
| irq | output | 1 | Level interrupt, any overflow flag set |

## Verification
The assertions assume that each event input counts once for every cycle it is high, so a held level counts as a run of pulses. They also assume that software changes the configuration only through whole-word writes. Beyond that, they need nothing from the inputs except a clean reset.

The stimulus changes every input on the falling clock edge, so each write and each event is seen at exactly one rising edge. The counter width is reduced in the bench, so a wrap happens within a few hundred cycles and the flag and interrupt behaviour can be reached.

// File: rtl/txn_event_bank.sv
module txn_event_bank #(
  parameter int CNT_W = 32,
  parameter logic [11:0] CFG_ADDR  = 12'h54c,
  parameter logic [11:0] OVF_ADDR  = 12'h560,
  parameter logic [11:0] DATA_BASE = 12'h634
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  evt_pulse,
  output logic        irq
);
  localparam int NCNT    = 5;
  localparam int EN_LSB  = 0;
  localparam int RST_LSB = 5;
  localparam int CLR_LSB = 18;
  localparam logic [31:0] CFG_MASK =
    ({{(32-NCNT){1'b0}}, {NCNT{1'b1}}} << EN_LSB) |
    ({{(32-NCNT){1'b0}}, {NCNT{1'b1}}} << RST_LSB) |
    ({{(32-NCNT){1'b0}}, {NCNT{1'b1}}} << CLR_LSB);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [31:0]      cfg;
  logic [NCNT-1:0]  en, hold_zero, clr, inc, wrap, ovf;
  logic [CNT_W-1:0] cnt [NCNT];

  assign en        = cfg[EN_LSB  +: NCNT];
  assign hold_zero = cfg[RST_LSB +: NCNT];
  assign clr       = cfg[CLR_LSB +: NCNT];
  assign inc       = {evt_pulse, 1'b1};
  assign irq       = |ovf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             cfg <= '0;
    else if (reg_wen && reg_addr == CFG_ADDR) cfg <= reg_wdata & CFG_MASK;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    assign wrap[g] = en[g] && inc[g] && !hold_zero[g] && cnt[g] == CNT_MAX;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               cnt[g] <= '0;
      else if (hold_zero[g])    cnt[g] <= '0;
      else if (en[g] && inc[g]) cnt[g] <= cnt[g] + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       ovf[g] <= 1'b0;
      else if (clr[g])  ovf[g] <= 1'b0;
      else if (wrap[g]) ovf[g] <= 1'b1;

    a_r3_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hold_zero[g] |=> cnt[g] == '0);
    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[g] && !hold_zero[g]) |=> $stable(cnt[g]));
    a_r5_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && inc[g] && !hold_zero[g] && !clr[g] && cnt[g] == CNT_MAX) |=> (ovf[g] && cnt[g] == '0));
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[g] && !clr[g]) |=> ovf[g]);
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |=> !ovf[g]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_ADDR)      reg_rdata = cfg;
    else if (reg_addr == OVF_ADDR) reg_rdata[NCNT-1:0] = ovf;
    else
      for (int i = 0; i < NCNT; i++)
        if (reg_addr == DATA_BASE + 12'(4 * i)) reg_rdata[CNT_W-1:0] = cnt[i];
  end
endmodule

// File: tb/test_txn_event_bank.sv
module test_txn_event_bank;
  localparam int W = 8;
  localparam logic [11:0] CFG = 12'h54c, OVF = 12'h560, DAT = 12'h634;
  // cfg enables, event mask, cycles
  localparam logic [16:0] VEC [8] = '{
    {5'h1F, 4'hF, 8'd10}, {5'h1F, 4'h5, 8'd7},  {5'h1F, 4'hA, 8'd4},
    {5'h0A, 4'hF, 8'd9},  {5'h15, 4'h3, 8'd6},  {5'h00, 4'hF, 8'd12},
    {5'h1E, 4'h8, 8'd3},  {5'h1F, 4'h0, 8'd5}};

  logic clk = 0, rst_n = 0, reg_wen = 0, irq;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0] evt_pulse = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_cfg;
  logic [W-1:0] m_cnt [5];
  logic [4:0] m_ovf;

  always #4 clk = ~clk;

  txn_event_bank #(.CNT_W(W)) i_txn_event_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq));

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_cfg <= 0; m_ovf <= 0;
      for (int i = 0; i < 5; i++) m_cnt[i] <= 0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        logic hit;
        hit = m_cfg[i] && (i == 0 || evt_pulse[i-1]);
        if (m_cfg[5+i]) m_cnt[i] <= 0;
        else if (hit) m_cnt[i] <= m_cnt[i] + 1'b1;
        if (m_cfg[18+i]) m_ovf[i] <= 0;
        else if (hit && !m_cfg[5+i] && m_cnt[i] == '1) m_ovf[i] <= 1;
      end
      if (reg_wen && reg_addr == CFG) m_cfg <= reg_wdata & 32'h007C03FF;
    end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(DAT + 12'(4 * i), v);
      chk(req, v, {24'h0, m_cnt[i]});
    end
    rd(OVF, v);
    chk(req, v, {27'h0, m_ovf});
    chk(req, {31'h0, irq}, {31'h0, m_ovf != 0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    cyc(3); rst_n = 1;
    // R1 reset state
    rd(CFG, v); chk("R1", v, 0);
    rd(OVF, v); chk("R1", v, 0);
    for (int i = 0; i < 5; i++) begin rd(DAT + 12'(4 * i), v); chk("R1", v, 0); end
    chk("R1", {31'h0, irq}, 0);

    // R2 configuration field layout
    wr(CFG, 32'hFFFFFFFF); rd(CFG, v); chk("R2", v, 32'h007C03FF);
    wr(CFG, 32'h000003E0); wr(CFG, 0);
    rd(OVF, v); chk("R2", v, 0);

    // R4 R8 table of enable and event patterns
    for (int k = 0; k < 8; k++) begin
      wr(CFG, {27'h0, VEC[k][16:12]});
      @(negedge clk); evt_pulse = VEC[k][11:8];
      cyc(int'(VEC[k][7:0]));
      evt_pulse = 0;
      check_all("R4");
    end
    rd(DAT + 12'd12, v); chk("R8", v, {24'h0, m_cnt[3]});

    // R3 reset bit holds counter 2 at zero while enabled with events
    wr(CFG, 32'h0000009F); evt_pulse = 4'hF; cyc(6);
    rd(DAT + 12'd8, v); chk("R3", v, 0);
    evt_pulse = 0;
    wr(CFG, 32'h0000001F); check_all("R3");

    // R5 R7 wrap of counter 0 sets flag and irq
    wr(CFG, 32'h00000020); wr(CFG, 32'h00000001);
    cyc(250); chk("R7", {31'h0, irq}, 0);
    cyc(10);
    rd(OVF, v); chk("R5", v[0], 1);
    chk("R7", {31'h0, irq}, 1);
    check_all("R5");

    // R6 sticky, then clear held over another wrap
    cyc(40); rd(OVF, v); chk("R6", v[0], 1);
    wr(CFG, 32'h00040001); cyc(300);
    rd(OVF, v); chk("R6", v, 0); chk("R7", {31'h0, irq}, 0);
    wr(CFG, 32'h00000001); cyc(5);
    rd(OVF, v); chk("R6", v, 0);
    check_all("R6");

    // R9 unmapped and read-only offsets
    rd(12'h000, v); chk("R9", v, 0);
    rd(12'h548, v); chk("R9", v, 0);
    wr(12'h550, 32'hFFFFFFFF); rd(CFG, v); chk("R9", v, 32'h00000001);
    wr(CFG, 0);
    wr(OVF, 32'h0000001F); rd(OVF, v); chk("R9", v, {27'h0, m_ovf});
    wr(DAT + 12'd4, 32'h000000AA); rd(DAT + 12'd4, v); chk("R9", v, {24'h0, m_cnt[1]});
    check_all("R9");

    finish_run();
  end
endmodule